// File: doc/BRIEF.md
# Ling Pseudo-Carry Lookahead Adder

This block is a purely combinational two's-complement adder with a parameterised width that defaults to 16 bits. It takes two operands and a carry-in. It returns the sum, the carry-out and a signed-overflow flag. The bits are split into groups of four.

The carry network does not pass ordinary carries from bit to bit. Instead it carries a Ling pseudo-carry. Each bit contributes a generate term (x AND y) and a transmit term (x OR y). Inside a group, every pseudo-carry follows directly from the pseudo-carry that enters the group. A lookahead stage derives each group's incoming pseudo-carry from group-level generate and transmit terms.

The true carry into a bit is recovered only where a sum bit needs it, as the pseudo-carry AND the transmit of the bit below. The external carry-in is taken as the pseudo-carry into bit 0, with the transmit below bit 0 fixed at 1.

Top module: `ling_cla_adder`

## Requirements
- R1: `sum` equals the low 16 bits of op_a + op_b + carry_in, for every input combination.
- R2: `carry_out` equals bit 16 of the 17-bit result of op_a + op_b + carry_in.
- R3: `overflow` is 1 exactly when op_a[15] equals op_b[15] and sum[15] differs from them. When the operand signs differ, `overflow` is 0.
- R4: With carry_in at 1 and op_b at 0, `sum` is op_a + 1. With carry_in at 0 and op_b at 0, `sum` is op_a and carry_out is 0.
- R5: All-ones plus zero with carry_in at 1 gives sum 0x0000 and carry_out 1. All-ones plus all-ones with carry_in at 1 gives sum 0xFFFF and carry_out 1. Neither case raises overflow.
- R6: A carry started in one group reaches every higher group. For example, 0x0FFF + 0x0001 gives 0x1000, and 0x7FFF + 0x0001 gives 0x8000 with overflow set.
- R7: Alternating-bit operands (0xAAAA, 0x5555), with either carry-in value, give the arithmetic sum and carry-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |
| overflow | output | 1 | Two's-complement overflow |

## Verification
The block holds no state, so a wrong pseudo-carry shows on the same input vector as a wrong sum bit at the next position up. It can also show as a wrong carry-out or overflow when the fault sits at the top. A fault in a group's lookahead term shows only when a carry must cross that group boundary. Long carry chains, all-ones operands and alternating patterns are therefore driven next to random vectors. Each result is compared with an arithmetic model half a cycle after the operands change.

// File: rtl/ling_cla_adder.sv
module ling_cla_adder #(
  parameter int WIDTH = 16,
  parameter int GRP   = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             overflow
);
  localparam int NGRP = WIDTH / GRP;

  logic [WIDTH-1:0] gen, tra;
  logic [WIDTH:0]   tx;
  logic [NGRP-1:0]  grp_g, grp_t;
  logic [NGRP:0]    grp_h;
  logic [WIDTH:0]   hp, cy;

  assign gen = op_a & op_b;
  assign tra = op_a | op_b;
  assign tx  = {tra, 1'b1};

  for (genvar j = 0; j < NGRP; j++) begin : g_grp
    localparam int B = j * GRP;
    logic             gg, gt;
    logic [GRP-1:0]   hloc;

    always_comb begin
      gg = 1'b0;
      gt = 1'b1;
      for (int k = 0; k < GRP; k++) begin
        gg = gen[B+k] | (tx[B+k] & gg);
        gt = tx[B+k] & gt;
      end
    end

    always_comb begin
      for (int k = 0; k < GRP; k++) begin
        logic acc, run;
        run = 1'b1;
        for (int n = 0; n < k; n++) run = run & tx[B+n];
        acc = run & grp_h[j];
        for (int m = 0; m < k; m++) begin
          logic pr;
          pr = 1'b1;
          for (int n = m + 1; n < k; n++) pr = pr & tx[B+n];
          acc = acc | (gen[B+m] & pr);
        end
        hloc[k] = acc;
      end
    end

    assign grp_g[j] = gg;
    assign grp_t[j] = gt;
    assign hp[B+GRP-1:B] = hloc;
  end

  always_comb begin
    grp_h[0] = carry_in;
    for (int j = 1; j <= NGRP; j++) begin
      logic acc, run;
      run = 1'b1;
      for (int k = 0; k < j; k++) run = run & grp_t[k];
      acc = run & carry_in;
      for (int k = 0; k < j; k++) begin
        logic pr;
        pr = 1'b1;
        for (int n = k + 1; n < j; n++) pr = pr & grp_t[n];
        acc = acc | (grp_g[k] & pr);
      end
      grp_h[j] = acc;
    end
  end

  assign hp[WIDTH] = grp_h[NGRP];
  assign cy        = hp & tx;
  assign sum       = op_a ^ op_b ^ cy[WIDTH-1:0];
  assign carry_out = cy[WIDTH];
  assign overflow  = cy[WIDTH] ^ cy[WIDTH-1];

  // R6: recovered carries obey the plain ripple recurrence at every bit
  always_comb begin
    p_carry_in_r6: assert (cy[0] == carry_in);
    for (int i = 0; i < WIDTH; i++) begin
      p_ripple_match_r6: assert (cy[i+1] == (gen[i] | (tra[i] & cy[i])));
    end
  end

  always_comb begin
    p_total_r1: assert ({carry_out, sum} ==
      ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}));
    p_no_overflow_r3: assert ((op_a[WIDTH-1] == op_b[WIDTH-1]) || !overflow);
    p_ovf_sign_r3: assert (overflow ==
      ((op_a[WIDTH-1] == op_b[WIDTH-1]) && (sum[WIDTH-1] != op_a[WIDTH-1])));
  end
endmodule

// File: tb/test_ling_cla_adder.sv
module test_ling_cla_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] a, b;
    logic         ci;
    logic [W-1:0] s;
    logic         co, ov;
    string        req;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic carry_in = 1'b0;
  logic [W-1:0] sum;
  logic carry_out, overflow;

  int checks = 0, errors = 0;
  bit done = 0;
  item_t q[$];

  ling_cla_adder i_ling_cla_adder (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum(sum), .carry_out(carry_out), .overflow(overflow));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic ci, input string req);
    item_t it;
    logic [W:0] tot;
    @(posedge clk);
    #1;
    op_a = a; op_b = b; carry_in = ci;
    tot = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    it.a = a; it.b = b; it.ci = ci; it.req = req;
    it.s = tot[W-1:0];
    it.co = tot[W];
    it.ov = (a[W-1] == b[W-1]) && (tot[W-1] != a[W-1]);
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (sum !== it.s || carry_out !== it.co || overflow !== it.ov) begin
        errors++;
        $display("FAIL %s: a=%h b=%h ci=%b got s=%h co=%b ov=%b exp s=%h co=%b ov=%b",
                 it.req, it.a, it.b, it.ci, sum, carry_out, overflow,
                 it.s, it.co, it.ov);
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    drive(16'h0000, 16'h0000, 1'b0, "R1 zero");
    drive(16'h1234, 16'h0000, 1'b1, "R4 inc");
    drive(16'h1234, 16'h0000, 1'b0, "R4 pass");
    drive(16'hFFFF, 16'h0000, 1'b1, "R5 wrap");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R5 ones");
    drive(16'hFFFF, 16'hFFFF, 1'b0, "R2 ones");
    drive(16'h0FFF, 16'h0001, 1'b0, "R6 grp");
    drive(16'h00FF, 16'h0000, 1'b1, "R6 grp2");
    drive(16'h7FFF, 16'h0001, 1'b0, "R6 ovf");
    drive(16'h8000, 16'h8000, 1'b0, "R3 negovf");
    drive(16'h7FFF, 16'h8000, 1'b1, "R3 mixed");
    drive(16'hAAAA, 16'h5555, 1'b0, "R7 alt0");
    drive(16'hAAAA, 16'h5555, 1'b1, "R7 alt1");
    drive(16'hAAAA, 16'hAAAA, 1'b1, "R7 altsame");
    drive(16'h5555, 16'h5555, 1'b0, "R7 alt5");
    for (int i = 0; i < 400; i++)
      drive(W'($urandom), W'($urandom), 1'($urandom), "R1 R2 R3 rand");
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule